// File: doc/BRIEF.md
# Virtualized Timestamp Read Unit

This unit forms the value a guest observes when it reads a time register without leaving to the host. A request carries a register index, a snapshot of the free-running 64-bit timestamp counter, two control bits (offset enable and scaling enable), a 64-bit offset, a 64-bit fixed-point multiplier with 16 integer and 48 fraction bits, and a 64-bit value for any register that is not virtualized. The unit latches all of these on the request strobe. It then answers with a 64-bit result, presented as an upper and a lower 32-bit word, together with a one-cycle valid pulse.

Only the timestamp index is transformed. When scaling is on, the counter is multiplied by the multiplier as a full 128-bit product, and bits 111 down to 48 of that product are kept. The offset is then added modulo 2^64. The deadline-timer index never sees the offset and returns its supplied value untouched. Every other index also passes its supplied value straight through. The multiply is split into 32-bit partial products in its own pipeline stage, so each path has the same fixed latency and a new request can be issued on every cycle.

Top module: `tsc_view_unit`

## Requirements
- R1: For index 0x10 with offset enable at 0, the result equals the counter input captured with the request.
- R2: For index 0x10 with offset enable at 1 and scaling enable at 0, the result is counter plus offset modulo 2^64, wrapping with no saturation.
- R3: For index 0x10 with both control bits at 1, the result is bits [111:48] of the unsigned 128-bit product of counter and multiplier, plus the offset modulo 2^64.
- R4: For index 0x10, scaling enable has no effect while offset enable is 0: the raw counter is returned.
- R5: For index 0x6E0 (deadline timer), the result is the supplied register value unchanged, whatever the offset, scaling, counter and multiplier inputs hold.
- R6: For any index other than 0x10 and 0x6E0, the result is the supplied register value unchanged.
- R7: rsp_valid goes high exactly three rising edges after the edge that samples req_valid high, for one cycle per request, and requests on consecutive cycles give results on consecutive cycles in the same order.
- R8: The result is driven with bits [63:32] on rsp_hi and bits [31:0] on rsp_lo. After reset, rsp_valid, rsp_hi and rsp_lo are 0, and the outputs keep their last value while rsp_valid is low.
- R9: All request inputs are taken at the sampling edge. Changes to them in later cycles do not alter that request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| req_index | input | 32 | Register index being read |
| ctr_value | input | 64 | Current timestamp counter value |
| ofs_en | input | 1 | Offset enable control |
| scale_en | input | 1 | Scaling enable control |
| ofs_value | input | 64 | Offset added modulo 2^64 |
| mult_value | input | 64 | Scaling multiplier, 16.48 fixed point |
| other_value | input | 64 | Value returned for indices that are not virtualized |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_hi | output | 32 | Result bits [63:32] |
| rsp_lo | output | 32 | Result bits [31:0] |

## Verification
The hardest case to reach is a scaled read in which carries between partial products cross the bit-48 cut and reach the upper bits of the product. It only shows up when both operands have their high words populated and the result depends on every cross term. The bench drives all-ones and mixed-pattern operands for this, and it also uses a multiplier of exactly 1.0 as a sanity case. It computes each expected value from a 128-bit product of its own. A second hard case is keeping three requests in flight at once while the inputs change every cycle. The bench covers it with back-to-back requests whose modes differ, and it scrambles all inputs in the cycle after each strobe.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
    localparam int CW          = 64;
    localparam int HALF_W      = CW / 2;
    localparam int LIMB_W      = 32;
    localparam int NLIMB       = CW / LIMB_W;
    localparam int NPP         = NLIMB * NLIMB;
    localparam int PW          = 2 * CW;
    localparam int SCALE_SHIFT = 48;
    localparam int IDX_W       = 32;

    localparam logic [IDX_W-1:0] IDX_TSC      = 32'h0000_0010;
    localparam logic [IDX_W-1:0] IDX_DEADLINE = 32'h0000_06E0;

    typedef enum logic [1:0] {
        SEL_RAW   = 2'd0,
        SEL_OFS   = 2'd1,
        SEL_SCALE = 2'd2,
        SEL_PASS  = 2'd3
    } sel_e;

    typedef struct packed {
        logic          valid;
        sel_e          sel;
        logic [CW-1:0] base;
        logic [CW-1:0] ofs;
        logic [CW-1:0] mult;
    } cap_t;

    typedef struct packed {
        logic          valid;
        sel_e          sel;
        logic [CW-1:0] base;
        logic [CW-1:0] ofs;
    } meta_t;

    function automatic sel_e pick_path(logic [IDX_W-1:0] idx, logic oe, logic se);
        if (idx != IDX_TSC) return SEL_PASS;
        if (!oe)            return SEL_RAW;
        if (!se)            return SEL_OFS;
        return SEL_SCALE;
    endfunction
endpackage

// File: rtl/tsv_capture.sv
module tsv_capture
    import tsv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_index,
    input  logic [CW-1:0]    ctr_value,
    input  logic             ofs_en,
    input  logic             scale_en,
    input  logic [CW-1:0]    ofs_value,
    input  logic [CW-1:0]    mult_value,
    input  logic [CW-1:0]    other_value,
    output cap_t             cap_q
);
    sel_e path_d;

    always_comb begin
        path_d = pick_path(req_index, ofs_en, scale_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.valid <= req_valid;
            if (req_valid) begin
                cap_q.sel  <= path_d;
                cap_q.base <= (path_d == SEL_PASS) ? other_value : ctr_value;
                cap_q.ofs  <= ofs_value;
                cap_q.mult <= mult_value;
            end
        end
    end

    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> cap_q.valid);
    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !cap_q.valid);
endmodule

// File: rtl/tsv_scale_mult.sv
module tsv_scale_mult
    import tsv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cap_t            cap_q,
    output meta_t           meta_q,
    output logic [2*LIMB_W-1:0] pp_q [NPP]
);
    genvar gi, gj;
    generate
        for (gi = 0; gi < NLIMB; gi++) begin : g_a
            for (gj = 0; gj < NLIMB; gj++) begin : g_b
                logic [LIMB_W-1:0] a_limb;
                logic [LIMB_W-1:0] b_limb;
                assign a_limb = cap_q.base[gi*LIMB_W +: LIMB_W];
                assign b_limb = cap_q.mult[gj*LIMB_W +: LIMB_W];
                always_ff @(posedge clk) begin
                    if (rst) begin
                        pp_q[gi*NLIMB+gj] <= '0;
                    end else if (cap_q.valid && cap_q.sel == SEL_SCALE) begin
                        pp_q[gi*NLIMB+gj] <= (2*LIMB_W)'(a_limb) * (2*LIMB_W)'(b_limb);
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
        end else begin
            meta_q.valid <= cap_q.valid;
            if (cap_q.valid) begin
                meta_q.sel  <= cap_q.sel;
                meta_q.base <= cap_q.base;
                meta_q.ofs  <= cap_q.ofs;
            end
        end
    end

    assert_stage_R7: assert property (@(posedge clk) disable iff (rst)
        cap_q.valid |=> meta_q.valid);
endmodule

// File: rtl/tsv_finish.sv
module tsv_finish
    import tsv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  meta_t               meta_q,
    input  logic [2*LIMB_W-1:0] pp_q [NPP],
    output logic                rsp_valid,
    output logic [HALF_W-1:0]   rsp_hi,
    output logic [HALF_W-1:0]   rsp_lo
);
    logic [PW-1:0] prod;
    logic [CW-1:0] scaled;
    logic [CW-1:0] result_d;

    always_comb begin
        prod = '0;
        for (int i = 0; i < NLIMB; i++) begin
            for (int j = 0; j < NLIMB; j++) begin
                prod = prod + (PW'(pp_q[i*NLIMB+j]) << (LIMB_W * (i + j)));
            end
        end
        scaled = prod[SCALE_SHIFT +: CW];
    end

    always_comb begin
        unique case (meta_q.sel)
            SEL_OFS:   result_d = meta_q.base + meta_q.ofs;
            SEL_SCALE: result_d = scaled + meta_q.ofs;
            default:   result_d = meta_q.base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hi    <= '0;
            rsp_lo    <= '0;
        end else begin
            rsp_valid <= meta_q.valid;
            if (meta_q.valid) begin
                rsp_hi <= result_d[CW-1:HALF_W];
                rsp_lo <= result_d[HALF_W-1:0];
            end
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !meta_q.valid |=> $stable({rsp_hi, rsp_lo}));
    assert_unchanged_R6: assert property (@(posedge clk) disable iff (rst)
        (meta_q.valid && (meta_q.sel == SEL_PASS || meta_q.sel == SEL_RAW))
        |=> ({rsp_hi, rsp_lo} == $past(meta_q.base)));
endmodule

// File: rtl/tsc_view_unit.sv
module tsc_view_unit
    import tsv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [CW-1:0]     ctr_value,
    input  logic              ofs_en,
    input  logic              scale_en,
    input  logic [CW-1:0]     ofs_value,
    input  logic [CW-1:0]     mult_value,
    input  logic [CW-1:0]     other_value,
    output logic              rsp_valid,
    output logic [HALF_W-1:0] rsp_hi,
    output logic [HALF_W-1:0] rsp_lo
);
    cap_t                cap_q;
    meta_t               meta_q;
    logic [2*LIMB_W-1:0] pp_q [NPP];

    tsv_capture u_capture (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_index   (req_index),
        .ctr_value   (ctr_value),
        .ofs_en      (ofs_en),
        .scale_en    (scale_en),
        .ofs_value   (ofs_value),
        .mult_value  (mult_value),
        .other_value (other_value),
        .cap_q       (cap_q)
    );

    tsv_scale_mult u_mult (
        .clk    (clk),
        .rst    (rst),
        .cap_q  (cap_q),
        .meta_q (meta_q),
        .pp_q   (pp_q)
    );

    tsv_finish u_finish (
        .clk       (clk),
        .rst       (rst),
        .meta_q    (meta_q),
        .pp_q      (pp_q),
        .rsp_valid (rsp_valid),
        .rsp_hi    (rsp_hi),
        .rsp_lo    (rsp_lo)
    );
endmodule

// File: tb/tsc_view_unit_tb.sv
module tsc_view_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_index;
    logic [63:0] ctr_value, ofs_value, mult_value, other_value;
    logic        ofs_en, scale_en;
    logic        rsp_valid;
    logic [31:0] rsp_hi, rsp_lo;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tsc_view_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .ctr_value(ctr_value), .ofs_en(ofs_en), .scale_en(scale_en),
        .ofs_value(ofs_value), .mult_value(mult_value), .other_value(other_value),
        .rsp_valid(rsp_valid), .rsp_hi(rsp_hi), .rsp_lo(rsp_lo)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(logic [31:0] idx, logic [63:0] c, logic oe,
                                          logic se, logic [63:0] o, logic [63:0] m,
                                          logic [63:0] oth);
        logic [127:0] p;
        if (idx != 32'h10) return oth;
        if (!oe) return c;
        if (!se) return c + o;
        p = {64'd0, c} * {64'd0, m};
        return p[111:48] + o;
    endfunction

    task automatic scramble();
        req_valid   = 1'b0;
        req_index   = 32'h10;
        ctr_value   = 64'hDEAD_BEEF_F00D_CAFE;
        ofs_en      = 1'b1;
        scale_en    = 1'b1;
        ofs_value   = 64'h5555_5555_5555_5555;
        mult_value  = 64'hFFFF_0000_FFFF_0000;
        other_value = 64'hAAAA_AAAA_AAAA_AAAA;
    endtask

    task automatic drive(logic [31:0] idx, logic [63:0] c, logic oe, logic se,
                         logic [63:0] o, logic [63:0] m, logic [63:0] oth);
        req_valid = 1'b1; req_index = idx; ctr_value = c; ofs_en = oe;
        scale_en = se; ofs_value = o; mult_value = m; other_value = oth;
    endtask

    // one request; checks latency (R7), value and split (R8); inputs scrambled after strobe (R9)
    task automatic run_one(string req, logic [31:0] idx, logic [63:0] c, logic oe,
                           logic se, logic [63:0] o, logic [63:0] m, logic [63:0] oth);
        logic [63:0] exp;
        exp = model(idx, c, oe, se, o, m, oth);
        @(negedge clk); drive(idx, c, oe, se, o, m, oth);
        @(negedge clk); scramble();
        @(negedge clk); check("R7 early valid", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        check("R7 valid at 3 edges", {63'd0, rsp_valid}, 64'd1);
        check(req, {rsp_hi, rsp_lo}, exp);
        @(negedge clk);
        check("R8 hold after pulse", {rsp_hi, rsp_lo}, exp);
        check("R7 single pulse", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8 reset valid", {63'd0, rsp_valid}, 64'd0);
        check("R8 reset data", {rsp_hi, rsp_lo}, 64'd0);
    endtask

    task automatic t_raw();
        run_one("R1 raw", 32'h10, 64'h0123_4567_89AB_CDEF, 0, 0, 64'd99, 64'd7, 64'd1);
        run_one("R4 scale ignored", 32'h10, 64'hFEDC_BA98_7654_3210, 0, 1,
                64'd99, 64'h0002_0000_0000_0000, 64'd1);
    endtask

    task automatic t_offset();
        run_one("R2 offset add", 32'h10, 64'd1000, 1, 0, 64'd234, 64'd0, 64'd0);
        run_one("R2 negative wrap", 32'h10, 64'd3, 1, 0, -64'sd5, 64'd0, 64'd0);
        run_one("R2 overflow wrap", 32'h10, 64'hFFFF_FFFF_FFFF_FFF0, 1, 0, 64'h20, 64'd0, 64'd0);
    endtask

    task automatic t_scale();
        run_one("R3 unity", 32'h10, 64'h1234_5678_9ABC_DEF0, 1, 1, 64'd0,
                64'h0001_0000_0000_0000, 64'd0);
        run_one("R3 x2.5 plus ofs", 32'h10, 64'h0000_0010_0000_0000, 1, 1, 64'd17,
                64'h0002_8000_0000_0000, 64'd0);
        run_one("R3 all ones", 32'h10, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 64'd1,
                64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        run_one("R3 mixed carries", 32'h10, 64'h8000_0001_FFFF_0001, 1, 1,
                64'hFFFF_FFFF_0000_0000, 64'h0000_FFFF_8000_FFFF, 64'd0);
    endtask

    task automatic t_deadline();
        run_one("R5 deadline ofs on", 32'h6E0, 64'h1111, 1, 0, 64'h7777, 64'd0,
                64'h0BAD_0000_1234_5678);
        run_one("R5 deadline scaled", 32'h6E0, 64'h2222, 1, 1, 64'h7777,
                64'h0003_0000_0000_0000, 64'h0000_0042_0000_0099);
    endtask

    task automatic t_other();
        run_one("R6 other index", 32'h1B, 64'h3333, 1, 1, 64'h9, 64'h1, 64'hCAFE_0000_BEEF_0001);
        run_one("R6 near index", 32'h11, 64'h3333, 1, 0, 64'h9, 64'h1, 64'h0000_0000_0000_0005);
    endtask

    task automatic t_stream();
        logic [63:0] e0, e1, e2;
        e0 = model(32'h10, 64'd50, 1, 0, 64'd5, 64'd0, 64'd0);
        e1 = model(32'h10, 64'h0000_0100_0000_0000, 1, 1, 64'd0, 64'h0000_8000_0000_0000, 64'd0);
        e2 = model(32'h99, 64'd0, 0, 0, 64'd0, 64'd0, 64'h4242_4242_4242_4242);
        @(negedge clk); drive(32'h10, 64'd50, 1, 0, 64'd5, 64'd0, 64'd0);
        @(negedge clk); drive(32'h10, 64'h0000_0100_0000_0000, 1, 1, 64'd0, 64'h0000_8000_0000_0000, 64'd0);
        @(negedge clk); drive(32'h99, 64'd0, 0, 0, 64'd0, 64'd0, 64'h4242_4242_4242_4242);
        @(negedge clk); scramble();
        check("R7 stream first", {rsp_hi, rsp_lo}, e0);
        check("R7 stream valid", {63'd0, rsp_valid}, 64'd1);
        @(negedge clk);
        check("R9 stream second", {rsp_hi, rsp_lo}, e1);
        @(negedge clk);
        check("R6 stream third", {rsp_hi, rsp_lo}, e2);
        @(negedge clk);
        check("R7 stream end", {63'd0, rsp_valid}, 64'd0);
        check("R8 stream hold", {rsp_hi, rsp_lo}, e2);
    endtask

    task automatic t_split();
        run_one("R8 split halves", 32'h10, 64'h0000_0001_FFFF_FFFE, 0, 0, 64'd0, 64'd0, 64'd0);
        check("R8 hi word", {32'd0, rsp_hi}, 64'h1);
        check("R8 lo word", {32'd0, rsp_lo}, 64'hFFFF_FFFE);
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        scramble();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reset();
        t_raw();
        t_offset();
        t_scale();
        t_deadline();
        t_other();
        t_stream();
        t_split();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule